// File: doc/BRIEF.md
# Configurable Bidirectional Pad Cell Array

This block is a parameterized array of programmable pad cells, grouped into banks. It is meant for the edge of a programmable logic fabric. Each cell sits between one pad and the fabric. A pad is modeled as three separate signals: a value coming in, a value going out and a drive enable. The model has no true inout.

Each cell holds three one-bit storage elements: a capture flop for the incoming pad value, a flop for outgoing data and a flop for the drive enable. Three static configuration bits per cell set its behaviour:

- whether outgoing data is combinational or registered;
- whether the drive enable is combinational or registered;
- whether the drive enable comes from the cell's own fabric signal or from a control line shared by the whole bank.

The fabric always sees the live pad value and the captured pad value side by side. Each bank has a shared enable line and a shared clock-enable line, and both reach every cell in that bank. All flops share one clock and one asynchronous active-low reset. The configuration is static and changes only while reset is asserted. No data stream here has back-pressure, so every pin is a plain level signal and none uses a valid/ready handshake.

Top module: `io_cell_array`

## Requirements
- R1: While reset is low, all three flops of every cell read 0. A cell with a registered enable therefore has pad_oe = 0, and fab_din_reg = 0.
- R2: fab_din_raw[i] equals pad_in[i] in the same cycle. fab_din_reg[i] equals the pad_in[i] sampled at the last clock edge on which the cell was loading.
- R3: When cfg_out_reg[i] = 0 and the cell is driving, pad_out[i] equals fab_dout[i] in the same cycle, with zero latency.
- R4: When cfg_out_reg[i] = 1 and the cell is driving, pad_out[i] equals the fab_dout[i] sampled at the last loading edge. This gives one cycle of latency.
- R5: When cfg_oe_reg[i] = 0, pad_oe[i] equals the selected enable source in the same cycle. When cfg_oe_reg[i] = 1, pad_oe[i] equals the source sampled at the last loading edge.
- R6: When cfg_oe_bank[i] = 1, the enable source is bank_oe of the cell's bank. When cfg_oe_bank[i] = 0, it is fab_oe[i].
- R7: pad_out[i] is 0 whenever pad_oe[i] is 0.
- R8: A cell loads its three flops only on an edge where both fab_ce[i] and bank_ce of its bank are 1. On any other edge all three hold their values.
- R9: The configuration inputs stay constant whenever reset is high.
- R10: Cell i belongs to bank i / CELLS_PER_BANK, with cells numbered from bit 0. The bank_oe and bank_ce lines of one bank never affect cells of another bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for every flop |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_out_reg | input | NUM_BANKS*CELLS_PER_BANK | Per cell: 1 selects registered outgoing data |
| cfg_oe_reg | input | NUM_BANKS*CELLS_PER_BANK | Per cell: 1 selects registered drive enable |
| cfg_oe_bank | input | NUM_BANKS*CELLS_PER_BANK | Per cell: 1 takes the enable from its bank line |
| bank_oe | input | NUM_BANKS | Shared drive enable, one per bank |
| bank_ce | input | NUM_BANKS | Shared clock enable, one per bank |
| fab_dout | input | NUM_BANKS*CELLS_PER_BANK | Outgoing data from the fabric |
| fab_oe | input | NUM_BANKS*CELLS_PER_BANK | Per-cell drive enable from the fabric |
| fab_ce | input | NUM_BANKS*CELLS_PER_BANK | Per-cell clock enable from the fabric |
| pad_in | input | NUM_BANKS*CELLS_PER_BANK | Value arriving at each pad |
| fab_din_raw | output | NUM_BANKS*CELLS_PER_BANK | Live pad value to the fabric |
| fab_din_reg | output | NUM_BANKS*CELLS_PER_BANK | Captured pad value to the fabric |
| pad_out | output | NUM_BANKS*CELLS_PER_BANK | Value driven onto each pad |
| pad_oe | output | NUM_BANKS*CELLS_PER_BANK | Drive enable of each pad |

## Verification
The bench builds the array with NUM_BANKS = 2 and CELLS_PER_BANK = 4. Those eight cells can hold all eight configuration combinations at once, and two banks make it possible to check that one bank's controls never leak into the other. The configuration is rotated across the cells eight times, with a reset between rotations. As a result, every cell index runs every combination. The live-versus-captured views and the one-edge latency can then be checked against a model for each cell.

// File: rtl/io_bank_pkg.sv
package io_bank_pkg;

  // Static per-cell selections, held constant outside reset.
  typedef struct packed {
    logic out_reg;   // outgoing data taken from the data flop
    logic oe_reg;    // drive enable taken from the enable flop
    logic oe_bank;   // enable source is the bank-wide line
  } cell_cfg_t;

  localparam int CFG_W = $bits(cell_cfg_t);

endpackage

// File: rtl/io_cell_reg.sv
module io_cell_reg #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ce,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (ce) q <= d;
  end

  AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(q)); // R8

  AST_REG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ce |=> (q == $past(d))); // R8

endmodule

// File: rtl/io_cell.sv
module io_cell
  import io_bank_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  cell_cfg_t cfg,
  input  logic      bank_oe,
  input  logic      bank_ce,
  input  logic      fab_dout,
  input  logic      fab_oe,
  input  logic      fab_ce,
  input  logic      pad_in,
  output logic      din_raw,
  output logic      din_reg,
  output logic      pad_out,
  output logic      pad_oe
);

  logic ld;
  logic oe_src;
  logic out_q;
  logic oe_q;
  logic out_sel;
  logic oe_sel;

  // Both the bank line and the cell line gate the flop clock.
  assign ld = bank_ce & fab_ce;

  // Pick the enable source before the flop, so the registered path sees the same choice.
  assign oe_src = cfg.oe_bank ? bank_oe : fab_oe;

  io_cell_reg #(.W(1)) u_in_reg (
    .clk(clk), .rst_n(rst_n), .ce(ld), .d(pad_in), .q(din_reg)
  );

  io_cell_reg #(.W(1)) u_out_reg (
    .clk(clk), .rst_n(rst_n), .ce(ld), .d(fab_dout), .q(out_q)
  );

  io_cell_reg #(.W(1)) u_oe_reg (
    .clk(clk), .rst_n(rst_n), .ce(ld), .d(oe_src), .q(oe_q)
  );

  assign din_raw = pad_in;

  // The two static path multiplexers.
  always_comb begin
    out_sel = cfg.out_reg ? out_q : fab_dout;
    oe_sel  = cfg.oe_reg  ? oe_q  : oe_src;
  end

  // An undriven pad presents a quiet 0 rather than stale data.
  assign pad_oe  = oe_sel;
  assign pad_out = oe_sel & out_sel;

  AST_CFG_STATIC: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(cfg)); // R9

  AST_IN_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    din_raw == pad_in); // R2

  AST_IN_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (din_reg == $past(pad_in))); // R2

  AST_OUT_COMB: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.out_reg && pad_oe) |-> (pad_out == fab_dout)); // R3

  AST_OUT_REG: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.out_reg && ld) |=> (!pad_oe || (pad_out == $past(fab_dout)))); // R4

  AST_OE_COMB_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.oe_reg && cfg.oe_bank) |-> (pad_oe == bank_oe)); // R6

  AST_OE_COMB_FAB: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.oe_reg && !cfg.oe_bank) |-> (pad_oe == fab_oe)); // R5

  AST_OE_REG: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.oe_reg && !ld) |=> $stable(pad_oe)); // R5

  AST_NO_STRAY_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !pad_oe |-> !pad_out); // R7

endmodule

// File: rtl/io_bank.sv
module io_bank
  import io_bank_pkg::*;
#(
  parameter int CELLS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CELLS-1:0]     cfg_out_reg,
  input  logic [CELLS-1:0]     cfg_oe_reg,
  input  logic [CELLS-1:0]     cfg_oe_bank,
  input  logic                 bank_oe,
  input  logic                 bank_ce,
  input  logic [CELLS-1:0]     fab_dout,
  input  logic [CELLS-1:0]     fab_oe,
  input  logic [CELLS-1:0]     fab_ce,
  input  logic [CELLS-1:0]     pad_in,
  output logic [CELLS-1:0]     din_raw,
  output logic [CELLS-1:0]     din_reg,
  output logic [CELLS-1:0]     pad_out,
  output logic [CELLS-1:0]     pad_oe
);

  for (genvar c = 0; c < CELLS; c++) begin : g_cell
    cell_cfg_t cfg_c;

    assign cfg_c = '{out_reg: cfg_out_reg[c], oe_reg: cfg_oe_reg[c], oe_bank: cfg_oe_bank[c]};

    io_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg     (cfg_c),
      .bank_oe (bank_oe),
      .bank_ce (bank_ce),
      .fab_dout(fab_dout[c]),
      .fab_oe  (fab_oe[c]),
      .fab_ce  (fab_ce[c]),
      .pad_in  (pad_in[c]),
      .din_raw (din_raw[c]),
      .din_reg (din_reg[c]),
      .pad_out (pad_out[c]),
      .pad_oe  (pad_oe[c])
    );
  end

  // A stalled bank freezes every captured value it holds.
  AST_BANK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_ce |=> $stable(din_reg)); // R8

endmodule

// File: rtl/io_cell_array.sv
module io_cell_array
  import io_bank_pkg::*;
#(
  parameter int NUM_BANKS      = 2,
  parameter int CELLS_PER_BANK = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [NUM_BANKS*CELLS_PER_BANK-1:0]   cfg_out_reg,
  input  logic [NUM_BANKS*CELLS_PER_BANK-1:0]   cfg_oe_reg,
  input  logic [NUM_BANKS*CELLS_PER_BANK-1:0]   cfg_oe_bank,
  input  logic [NUM_BANKS-1:0]                  bank_oe,
  input  logic [NUM_BANKS-1:0]                  bank_ce,
  input  logic [NUM_BANKS*CELLS_PER_BANK-1:0]   fab_dout,
  input  logic [NUM_BANKS*CELLS_PER_BANK-1:0]   fab_oe,
  input  logic [NUM_BANKS*CELLS_PER_BANK-1:0]   fab_ce,
  input  logic [NUM_BANKS*CELLS_PER_BANK-1:0]   pad_in,
  output logic [NUM_BANKS*CELLS_PER_BANK-1:0]   fab_din_raw,
  output logic [NUM_BANKS*CELLS_PER_BANK-1:0]   fab_din_reg,
  output logic [NUM_BANKS*CELLS_PER_BANK-1:0]   pad_out,
  output logic [NUM_BANKS*CELLS_PER_BANK-1:0]   pad_oe
);

  localparam int CPB = CELLS_PER_BANK;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    io_bank #(.CELLS(CPB)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_out_reg(cfg_out_reg[b*CPB +: CPB]),
      .cfg_oe_reg (cfg_oe_reg[b*CPB +: CPB]),
      .cfg_oe_bank(cfg_oe_bank[b*CPB +: CPB]),
      .bank_oe    (bank_oe[b]),
      .bank_ce    (bank_ce[b]),
      .fab_dout   (fab_dout[b*CPB +: CPB]),
      .fab_oe     (fab_oe[b*CPB +: CPB]),
      .fab_ce     (fab_ce[b*CPB +: CPB]),
      .pad_in     (pad_in[b*CPB +: CPB]),
      .din_raw    (fab_din_raw[b*CPB +: CPB]),
      .din_reg    (fab_din_reg[b*CPB +: CPB]),
      .pad_out    (pad_out[b*CPB +: CPB]),
      .pad_oe     (pad_oe[b*CPB +: CPB])
    );
  end

endmodule

// File: tb/sim_io_cell_array.sv
module sim_io_cell_array;

  localparam int NB  = 2;
  localparam int CPB = 4;
  localparam int N   = NB * CPB;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]  cfg_out_reg = '0, cfg_oe_reg = '0, cfg_oe_bank = '0;
  logic [NB-1:0] bank_oe = '0, bank_ce = '0;
  logic [N-1:0]  fab_dout = '0, fab_oe = '0, fab_ce = '0, pad_in = '0;
  logic [N-1:0]  fab_din_raw, fab_din_reg, pad_out, pad_oe;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  io_cell_array #(.NUM_BANKS(NB), .CELLS_PER_BANK(CPB)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_out_reg(cfg_out_reg), .cfg_oe_reg(cfg_oe_reg), .cfg_oe_bank(cfg_oe_bank),
    .bank_oe(bank_oe), .bank_ce(bank_ce),
    .fab_dout(fab_dout), .fab_oe(fab_oe), .fab_ce(fab_ce), .pad_in(pad_in),
    .fab_din_raw(fab_din_raw), .fab_din_reg(fab_din_reg),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // Reference state for each cell, built from the requirements.
  logic [N-1:0] m_in, m_out, m_oe, m_last_ld;

  function automatic logic src_of(int i);
    return cfg_oe_bank[i] ? bank_oe[i / CPB] : fab_oe[i];   // R6, R10
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_in <= '0; m_out <= '0; m_oe <= '0; m_last_ld <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (bank_ce[i / CPB] && fab_ce[i]) begin     // R8
          m_in[i]  <= pad_in[i];
          m_out[i] <= fab_dout[i];
          m_oe[i]  <= src_of(i);
        end
        m_last_ld[i] <= bank_ce[i / CPB] & fab_ce[i];
      end
    end
  end

  function automatic logic exp_oe(int i);
    return cfg_oe_reg[i] ? m_oe[i] : src_of(i);
  endfunction

  function automatic logic exp_out(int i);
    if (!exp_oe(i)) return 1'b0;
    return cfg_out_reg[i] ? m_out[i] : fab_dout[i];
  endfunction

  task automatic chk(input string tag, input string what, input int i,
                     input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s cell %0d cfg=%b%b%b actual=%b expected=%b", tag, what, i,
               cfg_oe_bank[i], cfg_oe_reg[i], cfg_out_reg[i], act, exp);
    end
  endtask

  task automatic check_all();
    for (int i = 0; i < N; i++) begin
      string t_oe, t_out, t_reg;
      if (!rst_n) begin
        t_oe = "R1"; t_out = "R1"; t_reg = "R1";
      end else begin
        if (cfg_oe_bank[i] && (bank_oe[0] != bank_oe[1])) t_oe = "R10";
        else if (cfg_oe_bank[i]) t_oe = "R6";
        else t_oe = "R5";
        if (!exp_oe(i)) t_out = "R7";
        else t_out = cfg_out_reg[i] ? "R4" : "R3";
        t_reg = m_last_ld[i] ? "R2" : "R8";
      end
      chk("R2", "din_raw", i, fab_din_raw[i], pad_in[i]);
      chk(t_reg, "din_reg", i, fab_din_reg[i], m_in[i]);
      chk(t_oe, "pad_oe", i, pad_oe[i], exp_oe(i));
      chk(t_out, "pad_out", i, pad_out[i], exp_out(i));
    end
  endtask

  // Drive at the falling edge, check shortly after, well before the next rising edge.
  task automatic step(input int ce_pct);
    @(negedge clk);
    fab_dout = N'($urandom);
    fab_oe   = N'($urandom);
    pad_in   = N'($urandom);
    bank_oe  = NB'($urandom);
    for (int i = 0; i < N; i++) fab_ce[i] = (($urandom % 100) < ce_pct);
    for (int b = 0; b < NB; b++) bank_ce[b] = (($urandom % 100) < ce_pct);
    #1;
    check_all();
  endtask

  task automatic step_directed(input logic [NB-1:0] boe, input logic [NB-1:0] bce,
                               input logic [N-1:0] fce);
    @(negedge clk);
    fab_dout = N'($urandom);
    fab_oe   = N'($urandom);
    pad_in   = N'($urandom);
    bank_oe  = boe;
    bank_ce  = bce;
    fab_ce   = fce;
    #1;
    check_all();
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int k = 0; k < 8; k++) begin
      // Configuration changes only while reset is held (R9).
      @(negedge clk);
      rst_n = 1'b0;
      for (int i = 0; i < N; i++) begin
        int combo = (i + k) % 8;
        cfg_out_reg[i] = combo[0];
        cfg_oe_reg[i]  = combo[1];
        cfg_oe_bank[i] = combo[2];
      end
      // Reset state with busy inputs (R1).
      for (int j = 0; j < 3; j++) step(100);
      @(negedge clk);
      rst_n = 1'b1;
      // First cycles after reset: no loads yet, registered paths still at 0 (R1).
      for (int j = 0; j < 2; j++) step_directed(NB'($urandom), '0, '1);
      // Full load rate, then mixed, then stalled banks.
      for (int j = 0; j < 60; j++) step(100);
      for (int j = 0; j < 150; j++) step(70);
      // One bank stalled while the other runs, with opposite bank enables (R10, R8).
      for (int j = 0; j < 10; j++) step_directed(2'b01, 2'b10, '1);
      for (int j = 0; j < 10; j++) step_directed(2'b10, 2'b01, '1);
      // Bank running but every cell enable low (R8).
      for (int j = 0; j < 8; j++) step_directed(NB'($urandom), '1, '0);
      for (int j = 0; j < 40; j++) step(30);
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule